// File: doc/BRIEF.md
# Two-Beat Double-Rate Shared-Bus SRAM Model

This block is a synthesizable cycle model of a synchronous static memory with one shared data bus. Commands are taken once per command period and every access moves exactly two data words. The double-rate bus is modelled with a beat clock `clk` at twice the command rate. The block keeps an internal phase flag and reports it on `k_rise`. When `k_rise` is 1, the next `clk` edge is a command-edge beat, which stands for the rising edge of the command clock. When `k_rise` is 0, the next edge is the opposite beat.

The shared bus is split into `dq_in`, `dq_out` and the output enable `dq_oe`, which marks the beats in which the block would drive the pad. Write data arrives late: one command period after its command, with one word on each beat. Each byte lane has its own active-low enable, and that enable is sampled with each beat. Read data comes back on the same fixed schedule.

A one-bit counter, preset from the low address bit, gives the address of each beat. A read issued directly behind a write always sees the new data. None of the pins has back-pressure. Every timing is fixed relative to the command edge, so the controller in front must follow the schedule in the requirements and cannot be stalled.

Top module: `b2_ddr_sram`

## Requirements
- R1: While `rst_n` is low, `dq_oe` is 0. On the first beat after reset is released, `k_rise` is 1 and the memory reads as all zeros.
- R2: `ld_n` and `rw` are sampled only on command-edge beats. `ld_n`=1 is a deselect whatever `rw` is. `ld_n`=0 with `rw`=0 is a write, and `ld_n`=0 with `rw`=1 is a read. Values on `ld_n`, `rw`, `addr`, `dq_in` and `bw_n` outside the scheduled beats change neither memory nor the outputs.
- R3: For a read taken at command edge n, `dq_out` carries beat 1 after edge n+2 and beat 2 after edge n+3. `dq_oe` is 1 in exactly those beats.
- R4: Beat 1 uses `addr` as given. Beat 2 uses `addr` with bit 0 inverted, for both values of bit 0.
- R5: For a write taken at command edge n, beat 1 is taken from `dq_in` at edge n+2 and beat 2 at edge n+3.
- R6: `bw_n[l]`=0 enables byte lane l, which is bits 8l+7:8l. The enable is sampled separately with each write beat, so a lane can be stored in beat 1, beat 2, both or neither.
- R7: A write with `bw_n` all ones on both beats leaves memory unchanged.
- R8: A read taken on the command edge right after a write returns the data that write stored, including on overlapping addresses.
- R9: `dq_oe` is 0 on every beat that is not a read-return beat, and in particular on both write-capture beats.
- R10: `k_rise` toggles on every beat after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Active-low command load strobe |
| rw | input | 1 | 1 = read, 0 = write, valid with ld_n low |
| addr | input | AW | Word address; bit 0 presets the burst counter |
| dq_in | input | DW | Incoming side of the shared data bus |
| bw_n | input | DW/8 | Active-low byte-lane write enables, per beat |
| k_rise | output | 1 | 1 when the next edge is a command-edge beat |
| dq_out | output | DW | Outgoing side of the shared data bus |
| dq_oe | output | 1 | Bus drive enable, high only on read-return beats |

## Verification
The hardest case to reach is a read whose return beats land directly behind write-capture beats for the same word pair. In that case the counter has just been preset from a different low bit, and only some lanes were enabled on each beat. The stimulus places writes with beat-specific masks on one command edge and reads of the same pair, or of its partner word, on the next. It also injects random load strobes on the opposite beats and random bus data on idle beats, so that any sampling on the wrong phase would corrupt the reference comparison.

// File: rtl/b2_sram_pkg.sv
package b2_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } beat_op_e;
endpackage

// File: rtl/b2_cmd_decode.sv
// Command capture on command-edge beats, burst stage and 1-bit beat counter.
module b2_cmd_decode
  import b2_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  output logic          k_rise,
  output beat_op_e      beat_op,
  output logic [AW-1:0] beat_addr
);
  logic          phase;      // 0: next edge is a command edge
  beat_op_e      cap_op;
  logic [AW-1:0] cap_addr;
  beat_op_e      brst_op;
  logic [AW-2:0] brst_hi;
  logic          lsb_cnt;

  assign k_rise = ~phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      cap_op   <= OP_IDLE;
      cap_addr <= '0;
      brst_op  <= OP_IDLE;
      brst_hi  <= '0;
      lsb_cnt  <= 1'b0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        // command edge: sample strobe, select, address; advance burst counter
        cap_op   <= ld_n ? OP_IDLE : (rw ? OP_READ : OP_WRITE);
        cap_addr <= addr;
        lsb_cnt  <= ~lsb_cnt;
      end else begin
        // opposite edge: move captured command into the burst stage, preset counter
        brst_op <= cap_op;
        brst_hi <= cap_addr[AW-1:1];
        lsb_cnt <= cap_addr[0];
      end
    end
  end

  assign beat_op   = brst_op;
  assign beat_addr = {brst_hi, lsb_cnt};
endmodule

// File: rtl/b2_lane_array.sv
// Memory split into byte lanes, each with its own write enable.
module b2_lane_array #(
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DW / LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] lane_en,
  output logic [DW-1:0]    rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (wr_en && lane_en[l]) begin
        store[addr] <= wdata[l*LANE_W +: LANE_W];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = store[addr];
  end
endmodule

// File: rtl/b2_return_stage.sv
// Registered read return and bus drive enable.
module b2_return_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_beat,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      dq_oe  <= rd_beat;
      dq_out <= rd_beat ? rdata : '0;
    end
  end
endmodule

// File: rtl/b2_ddr_sram.sv
module b2_ddr_sram
  import b2_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DW / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic             rw,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dq_in,
  input  logic [LANES-1:0] bw_n,
  output logic             k_rise,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  beat_op_e      beat_op;
  logic [AW-1:0] beat_addr;
  logic [DW-1:0] rdata;

  b2_cmd_decode #(.AW(AW)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_n     (ld_n),
    .rw       (rw),
    .addr     (addr),
    .k_rise   (k_rise),
    .beat_op  (beat_op),
    .beat_addr(beat_addr)
  );

  b2_lane_array #(.AW(AW), .DW(DW), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (beat_op == OP_WRITE),
    .addr   (beat_addr),
    .wdata  (dq_in),
    .lane_en(~bw_n),
    .rdata  (rdata)
  );

  b2_return_stage #(.DW(DW)) u_return (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_beat(beat_op == OP_READ),
    .rdata  (rdata),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );
endmodule

// File: rtl/b2_sram_checker.sv
module b2_sram_checker (
  input logic clk,
  input logic rst_n,
  input logic ld_n,
  input logic rw,
  input logic k_rise,
  input logic dq_oe
);
  logic started;
  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R10
  a_r10_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (k_rise != $past(k_rise)));

  // R3
  a_r3_read_two_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (k_rise && !ld_n && rw) |=> ##2 dq_oe ##1 dq_oe);

  // R3
  a_r3_oe_align: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dq_oe) || $fell(dq_oe)) |-> !k_rise);

  // R9
  a_r9_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (k_rise && !ld_n && !rw) |=> ##2 !dq_oe ##1 !dq_oe);
endmodule

bind b2_ddr_sram b2_sram_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ld_n  (ld_n),
  .rw    (rw),
  .k_rise(k_rise),
  .dq_oe (dq_oe)
);

// File: tb/test_b2_ddr_sram.sv
module test_b2_ddr_sram;
  localparam int AW = 6, DW = 16, LW = 8, NL = DW / LW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, ld_n = 1'b1, rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [NL-1:0] bw_n = '1;
  logic k_rise, dq_oe;
  logic [DW-1:0] dq_out;

  b2_ddr_sram #(.AW(AW), .DW(DW), .LANE_W(LW)) i_b2_ddr_sram (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
    .dq_in(dq_in), .bw_n(bw_n), .k_rise(k_rise), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, e = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] wd [int];
  logic [NL-1:0] wm [int];
  int wa [int];
  int ra [int];
  string rtag [int];
  logic exp_oe;
  logic [DW-1:0] exp_d;
  string exp_tag;

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (edge %0d)", req, what, act, exp, e);
    end
  endtask

  // One beat: update reference for edge e, clock, compare, drive next beat.
  task automatic tick();
    if (wa.exists(e))
      for (int l = 0; l < NL; l++)
        if (!bw_n[l]) ref_mem[wa[e]][l*LW +: LW] = dq_in[l*LW +: LW];
    if (ra.exists(e)) begin
      exp_oe = 1'b1; exp_d = ref_mem[ra[e]]; exp_tag = rtag[e];
    end else begin
      exp_oe = 1'b0; exp_d = '0; exp_tag = "R9";
    end
    chk(k_rise == (e % 2 == 0), "R10", "k_rise", DW'(k_rise), DW'(e % 2 == 0));
    @(posedge clk);
    @(negedge clk);
    chk(dq_oe == exp_oe, exp_oe ? "R3" : "R9", "dq_oe", DW'(dq_oe), DW'(exp_oe));
    if (exp_oe && dq_oe) chk(dq_out == exp_d, exp_tag, "dq_out", dq_out, exp_d);
    e++;
    ld_n = 1'b1;
    rw   = 1'($urandom);
    addr = AW'($urandom);
    if (e % 2 == 1) ld_n = 1'($urandom); // R2: noise on the opposite beat
    if (wd.exists(e)) begin
      dq_in = wd[e]; bw_n = wm[e];
    end else begin
      dq_in = DW'($urandom); bw_n = NL'($urandom);
    end
  endtask

  task automatic issue(bit wr, int a, logic [DW-1:0] d1, logic [DW-1:0] d2,
                       logic [NL-1:0] m1, logic [NL-1:0] m2, string tag);
    if (e % 2 == 1) tick();
    ld_n = 1'b0;
    rw   = !wr;
    addr = AW'(a);
    if (wr) begin
      wd[e+2] = d1; wm[e+2] = m1; wa[e+2] = a;
      wd[e+3] = d2; wm[e+3] = m2; wa[e+3] = a ^ 1;
    end else begin
      ra[e+2] = a;     rtag[e+2] = tag;
      ra[e+3] = a ^ 1; rtag[e+3] = tag;
    end
    tick();
    tick();
  endtask

  task automatic rd(int a, string tag);
    issue(1'b0, a, '0, '0, '1, '1, tag);
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) begin
      @(negedge clk);
      chk(dq_oe == 1'b0, "R1", "dq_oe in reset", DW'(dq_oe), '0);
    end
    rst_n = 1'b1;
    e = 0;
    chk(k_rise == 1'b1, "R1", "k_rise after reset", DW'(k_rise), 1);
    dq_in = DW'($urandom); bw_n = '1;

    // R1: memory starts at zero
    rd(0, "R1");
    rd(5, "R1");

    // R5: fill every pair with full masks, back to back
    for (int a = 0; a < DEPTH; a += 2)
      issue(1'b1, a, DW'($urandom), DW'($urandom), '0, '0, "R5");
    // R4: read with both values of bit 0
    for (int a = 0; a < 16; a++) rd(a, "R4");

    // R6: per-beat lane masks
    issue(1'b1, 8, 16'hA1A2, 16'hB1B2, 2'b10, 2'b01, "R6");
    rd(8, "R6");
    issue(1'b1, 10, 16'hC3C4, 16'hD5D6, 2'b00, 2'b11, "R6");
    rd(10, "R6");
    issue(1'b1, 15, 16'hE7E8, 16'hF9FA, 2'b11, 2'b00, "R6");
    rd(14, "R6");

    // R7: abort, then confirm untouched
    issue(1'b1, 12, 16'hDEAD, 16'hBEEF, 2'b11, 2'b11, "R7");
    rd(12, "R7");
    rd(13, "R7");

    // R8: read on the next command edge after a write
    issue(1'b1, 20, 16'h1234, 16'h5678, 2'b00, 2'b00, "R8");
    rd(20, "R8");
    issue(1'b1, 23, 16'h9ABC, 16'hDEF0, 2'b01, 2'b10, "R8");
    rd(22, "R8");
    rd(30, "R8");
    issue(1'b1, 30, 16'h0F0F, 16'hF0F0, 2'b00, 2'b00, "R8");
    rd(31, "R8");

    // R2: deselects with random select and noise, then verify memory
    idle(40);
    for (int a = 0; a < DEPTH; a += 2) rd(a, "R2");

    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 2)
        issue(1'b1, int'($urandom % DEPTH), DW'($urandom), DW'($urandom),
              NL'($urandom), NL'($urandom), "R5");
      else
        rd(int'($urandom % DEPTH), "R8");
      if ($urandom % 3 == 0) idle(2 * int'($urandom % 3));
    end
    idle(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule